// File: doc/BRIEF.md
# Fractional Tracking Sigma-Delta Dither

This block turns the fractional part of a tracking tuning word into a fast stream of small signed corrections. A downstream conditioner uses these corrections to switch a small group of fine-tracking varactors on and off. Each step of the stream is one varactor unit. Averaged over many cycles, the stream gives a frequency resolution of 1/256 of a single integer tracking step.

The modulator is a second-order noise shaper built from two cascaded first-order accumulators. Its clock is a divided oscillator clock that runs well above the reference rate, so most of the quantization noise lands at large frequency offsets. The fractional word arrives once per reference period and is captured on a reference strobe. The captured value is held until the next strobe. Each clock, the carries of the two stages are combined into one signed sample whose value lies in the range −1 to +2.

Top module: `trk_frac_dither`

## Requirements
- R1: While rst_n is low, and on the first sample after it goes high, dither_out is 0. Reset clears both accumulators, the held fraction and the stored second-stage carry.
- R2: On a rising clock edge where ref_strobe is 1, frac_in is captured into the held fraction. The accumulators first use the captured value at the next edge.
- R3: When ref_strobe is 0, frac_in has no effect. The held fraction, and therefore dither_out, behaves as if frac_in had not changed.
- R4: The first stage is an 8-bit accumulator. On every edge it adds the held fraction, modulo 256. Its carry c1 is 1 exactly when that sum reaches 256 or more.
- R5: The second stage is an 8-bit accumulator. On every edge it adds the new 8-bit residue of the first stage, modulo 256. Its carry c2 is 1 exactly when that sum reaches 256 or more.
- R6: dither_out is a 3-bit two's-complement register. After each edge it holds c1 + c2 − c2p. Here c1 and c2 are the carries produced at that edge, and c2p is the c2 produced at the previous edge (0 after reset).
- R7: dither_out is always one of −1, 0, +1 or +2.
- R8: A held fraction of 0 adds nothing to either accumulator. With all state cleared, dither_out stays at 0.
- R9: For any constant held fraction f, the sum of dither_out over 256·k consecutive cycles lies within ±1 of k·f.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate clock, divided from the oscillator |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_strobe | input | 1 | One-cycle pulse per reference period; captures frac_in |
| frac_in | input | 8 | Fractional tracking word, unsigned, in units of 1/256 step |
| dither_out | output | 3 | Signed varactor adjustment, two's complement, range −1..+2 |

## Verification
A wrong accumulator value, a lost carry or a wrong stored second-stage carry changes the output sequence. The effect appears on the output register one cycle after the faulty edge, so the bench compares every output sample with an arithmetic model of R4 to R6. The model is built from the requirements alone. A wrong capture of the fraction changes the running density of the stream. The window sums of R9 expose it within one 256-cycle period, even where individual samples happen to agree.

// File: rtl/trk_dither_pkg.sv
package trk_dither_pkg;
    localparam int FRAC_W   = 8;
    localparam int STAGES   = 2;
    localparam int OUT_W    = 3;
    localparam int OUT_MIN  = -1;
    localparam int OUT_MAX  = 2;

    typedef logic [FRAC_W-1:0]        frac_t;
    typedef logic signed [OUT_W-1:0]  dith_t;
endpackage

// File: rtl/trk_frac_hold.sv
module trk_frac_hold
    import trk_dither_pkg::*;
#(
    parameter int W = FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value_in,
    output logic [W-1:0] value_out
);
    typedef struct packed {
        logic [W-1:0] held;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.held = value_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value_out = st_q.held;

    // R2: a strobe captures the input word
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (value_out == $past(value_in)));

    // R3: without a strobe the held word does not move
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(value_out));
endmodule

// File: rtl/trk_mash_stage.sv
module trk_mash_stage
    import trk_dither_pkg::*;
#(
    parameter int W = FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] addend,
    output logic [W-1:0] residue,
    output logic         carry
);
    localparam int SUM_W = W + 1;

    typedef struct packed {
        logic [W-1:0] acc;
    } stage_state_t;

    stage_state_t      st_d, st_q;
    logic [SUM_W-1:0]  sum_full;

    always_comb begin
        sum_full = {1'b0, st_q.acc} + {1'b0, addend};
        st_d     = st_q;
        st_d.acc = sum_full[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign residue = sum_full[W-1:0];
    assign carry   = sum_full[W];

    // R8: a zero increment leaves the accumulator where it was
    a_r8_zero_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (addend == '0) |=> $stable(st_q.acc));

    // R4/R5: a zero increment never raises a carry
    a_r5_no_carry_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addend == '0) |-> !carry);
endmodule

// File: rtl/trk_mash_combine.sv
module trk_mash_combine
    import trk_dither_pkg::*;
#(
    parameter int OW = OUT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 c_first,
    input  logic                 c_second,
    output logic signed [OW-1:0] dith
);
    typedef struct packed {
        logic                 c2_prev;
        logic signed [OW-1:0] out;
    } comb_state_t;

    comb_state_t          st_d, st_q;
    logic signed [OW-1:0] term1, term2, term3;

    always_comb begin
        term1 = OW'(c_first);
        term2 = OW'(c_second);
        term3 = OW'(st_q.c2_prev);
        st_d         = st_q;
        st_d.out     = term1 + term2 - term3;
        st_d.c2_prev = c_second;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dith = st_q.out;

    // R7: output stays within the legal adjustment range
    a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
        (dith >= OW'(OUT_MIN)) && (dith <= OW'(OUT_MAX)));

    // R6: with no carries now and none stored, the next sample is zero
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_first && !c_second && !st_q.c2_prev) |=> (dith == '0));
endmodule

// File: rtl/trk_frac_dither.sv
module trk_frac_dither
    import trk_dither_pkg::*;
#(
    parameter int W  = FRAC_W,
    parameter int NS = STAGES,
    parameter int OW = OUT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_strobe,
    input  logic [W-1:0]         frac_in,
    output logic signed [OW-1:0] dither_out
);
    logic [W-1:0] chain [NS+1];
    logic [NS-1:0] carries;

    trk_frac_hold #(.W(W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ref_strobe),
        .value_in  (frac_in),
        .value_out (chain[0])
    );

    for (genvar gi = 0; gi < NS; gi++) begin : g_stage
        trk_mash_stage #(.W(W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .addend  (chain[gi]),
            .residue (chain[gi+1]),
            .carry   (carries[gi])
        );
    end

    trk_mash_combine #(.OW(OW)) u_combine (
        .clk      (clk),
        .rst_n    (rst_n),
        .c_first  (carries[0]),
        .c_second (carries[NS-1]),
        .dith     (dither_out)
    );

    // R1: the first sample after reset is zero
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (dither_out == '0));
endmodule

// File: tb/trk_frac_dither_bench.sv
module trk_frac_dither_bench;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_strobe = 1'b0;
    logic [7:0]       frac_in = 8'd0;
    logic signed [2:0] dither_out;

    int n_checks = 0;
    int n_bad    = 0;

    // model state, derived from R4..R6
    int m_frac, m_a1, m_a2, m_c2p, m_out;

    localparam int NVEC = 8;
    localparam int VEC_FRAC [NVEC] = '{1, 128, 255, 64, 3, 200, 85, 17};
    localparam int WIN_K = 4;

    always #4 clk = ~clk;

    trk_frac_dither u_trk_frac_dither (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_strobe (ref_strobe),
        .frac_in    (frac_in),
        .dither_out (dither_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_frac = 0; m_a1 = 0; m_a2 = 0; m_c2p = 0; m_out = 0;
    endtask

    // one clock: drive inputs, advance model, compare after the edge
    task automatic step(input logic stb, input int fr, input string req);
        int s1, s2, c1, c2;
        @(negedge clk);
        ref_strobe = stb;
        frac_in    = fr[7:0];
        s1 = m_a1 + m_frac;
        c1 = s1 / 256;
        s2 = m_a2 + (s1 % 256);
        c2 = s2 / 256;
        m_out = c1 + c2 - m_c2p;
        m_c2p = c2;
        m_a1  = s1 % 256;
        m_a2  = s2 % 256;
        if (stb) m_frac = fr;
        @(posedge clk);
        #1;
        check(req, int'(dither_out), m_out);
        if (dither_out < -1 || dither_out > 2)
            check("R7", int'(dither_out), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_strobe = 1'b0;
        @(posedge clk); #1;
        check("R1 during reset", int'(dither_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin : main
        int sum;
        model_reset();
        repeat (2) @(posedge clk);
        do_reset();
        step(1'b0, 0, "R1 first sample after reset");

        // table walk: R2, R4, R5, R6 sample by sample, R9 by window sum
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            step(1'b1, VEC_FRAC[v], "R2 capture");
            sum = 0;
            for (int i = 0; i < 256 * WIN_K; i++) begin
                step(1'b0, 0, "R6 sample");
                sum += int'(dither_out);
            end
            n_checks++;
            if (sum < WIN_K * VEC_FRAC[v] - 1 || sum > WIN_K * VEC_FRAC[v] + 1) begin
                n_bad++;
                $display("FAIL R9: actual=%0d expected=%0d+-1", sum, WIN_K * VEC_FRAC[v]);
            end
        end

        // R8: zero fraction from cleared state stays at zero
        do_reset();
        step(1'b1, 0, "R8 load zero");
        for (int i = 0; i < 300; i++) begin
            step(1'b0, 0, "R8 model");
            check("R8 zero output", int'(dither_out), 0);
        end

        // R3: changes on frac_in without strobe are ignored
        do_reset();
        step(1'b1, 0, "R3 load zero");
        for (int i = 0; i < 300; i++) begin
            step(1'b0, 255 - (i % 7), "R3 model");
            check("R3 ignored input", int'(dither_out), 0);
        end
        step(1'b1, 37, "R3 late load");
        sum = 0;
        for (int i = 0; i < 256; i++) begin
            step(1'b0, 200, "R3 held value");
            sum += int'(dither_out);
        end
        n_checks++;
        if (sum < 36 || sum > 38) begin
            n_bad++;
            $display("FAIL R3/R9: actual=%0d expected=37+-1", sum);
        end

        // R2: reloading mid-stream, state keeps running
        step(1'b1, 129, "R2 reload");
        for (int i = 0; i < 200; i++) step(1'b0, 0, "R2 after reload");

        // R1: reset mid-run clears output and state
        do_reset();
        step(1'b0, 99, "R1 after mid-run reset");
        for (int i = 0; i < 20; i++) begin
            step(1'b0, 99, "R1 cleared state");
            check("R1 quiet after reset", int'(dither_out), 0);
        end

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule